// File: doc/BRIEF.md
# Echo Character Input Multiplexer

This block builds the return serial line for a host that talks to the chip over a plain asynchronous link, framed as eight data bits, no parity and one stop bit. The block has no transmitter of its own. It echoes every received character back, so the host gets exactly one character for each one it sends, and the returned character has the same timing as the one sent. The middle of the echoed copy is overwritten with the live levels of four input pins, so the host reads those pins out of the data bits it gets back.

A falling edge on the idle line starts a packet timer that counts in half-bit steps on the system clock. The returned line copies the incoming line during the start bit and again from the most significant data bit onward, which keeps the framing correct. For half a bit after the start bit, the line is held at mark. Then four contiguous windows follow, each 1.5 bit cells wide, and each drives one input pin onto the line while the pin is sampled live. The timer re-arms at the middle of the stop bit, so a character sent straight after the previous one is caught.

Top module: `echo_input_mux`

## Requirements
- R1: While no character is in progress, including after reset, the returned line is high and follows the incoming line.
- R2: The returned start bit is low, copied from the incoming start bit.
- R3: From 1.0 to 1.5 bit periods after the start edge, the returned line is high whatever the incoming data bit 0 is.
- R4: The pins appear in index order, each for 1.5 bit cells starting 1.5 bit periods after the start edge. Returned data bit 1 (LSB is bit 0) equals pin 0, bit 2 equals pin 1, bit 4 equals pin 2 and bit 5 equals pin 3.
- R5: Returned data bit 7 and the stop bit are copies of the incoming line.
- R6: Pin levels are not latched. A pin change in the middle of its window shows on the returned line within that same window.
- R7: The timer re-arms at the middle of the stop bit, so characters sent back to back with no idle time each get their own complete echo.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rx_i | input | 1 | Serial line from the host (idle high) |
| pins_i | input | 4 | Live input pins returned in the echo |
| host_tx_o | output | 1 | Echoed serial line back to the host |

## Verification
All sixteen pin combinations are swept under several characters: all zeros, all ones, only the MSB set, only the MSB clear, and alternating bits. So a pin showing up in the wrong window, or data leaking through from the host character, shows as a mismatch against the expected pin value. The all-zero character checks that the mark half-bit is driven rather than copied. The MSB-only and MSB-clear characters check that bit 7 is passed through. A burst with no idle gap between characters checks the re-arm point, and a pin toggled in the middle of its window tells live sampling apart from latching.

// File: rtl/echo_mux_pkg.sv
package echo_mux_pkg;

    localparam int NUM_IN    = 4;
    localparam int HALF_W    = 5;
    localparam int GAP_HALF  = 2;
    localparam int WIN_BASE  = 3;
    localparam int WIN_SPAN  = 3;
    localparam int WIN_END   = WIN_BASE + NUM_IN * WIN_SPAN;
    localparam int END_HALF  = 18;
    localparam int PIN_W     = $clog2(NUM_IN);

    typedef enum logic [1:0] {
        SRC_LINE = 2'd0,
        SRC_MARK = 2'd1,
        SRC_PIN  = 2'd2
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [PIN_W-1:0] pin;
    } route_t;

    function automatic route_t route_for(input logic [HALF_W-1:0] half);
        route_t r;
        int     hv;
        hv    = int'(half);
        r.src = SRC_LINE;
        r.pin = '0;
        if (hv == GAP_HALF) begin
            r.src = SRC_MARK;
        end
        for (int i = 0; i < NUM_IN; i++) begin
            if (hv >= WIN_BASE + i * WIN_SPAN && hv < WIN_BASE + (i + 1) * WIN_SPAN) begin
                r.src = SRC_PIN;
                r.pin = PIN_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/echo_line_sync.sv
module echo_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign line_o = chain_q[STAGES-1];
    assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/echo_frame_timer.sv
module echo_frame_timer
    import echo_mux_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic [HALF_W-1:0] half_o
);
    localparam int HALF = CLKS_PER_BIT / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0]     CNT_LAST = CW'(HALF - 1);
    localparam logic [HALF_W-1:0] H_END    = HALF_W'(END_HALF);

    logic [CW-1:0]     cnt_q;
    logic [HALF_W-1:0] half_q;
    logic              busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            half_q <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                half_q <= '0;
            end
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            if (half_q == H_END) begin
                busy_q <= 1'b0;
                half_q <= '0;
            end else begin
                half_q <= half_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign half_o = half_q;

    p_half_range_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (half_q <= H_END));

    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q == CNT_LAST && half_q == H_END) |=> !busy_q);

    p_half_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != CNT_LAST) |=> $stable(half_q));

endmodule

// File: rtl/echo_phase_mux.sv
module echo_phase_mux
    import echo_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic              busy_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic [NUM_IN-1:0] pins_i,
    output logic              out_o
);
    route_t route;
    logic   next_bit;
    logic   out_q;

    always_comb begin
        route = route_for(half_i);
        if (!busy_i) begin
            next_bit = line_i;
        end else begin
            unique case (route.src)
                SRC_MARK: next_bit = 1'b1;
                SRC_PIN:  next_bit = pins_i[route.pin];
                default:  next_bit = line_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b1;
        else     out_q <= next_bit;
    end

    assign out_o = out_q;

    p_idle_follow_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_i |=> (out_o == $past(line_i)));

    p_gap_mark_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_i && half_i == HALF_W'(GAP_HALF)) |=> out_o);

    p_tail_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_i && half_i >= HALF_W'(WIN_END)) |=> (out_o == $past(line_i)));

endmodule

// File: rtl/echo_input_mux.sv
module echo_input_mux
    import echo_mux_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_rx_i,
    input  logic [3:0]  pins_i,
    output logic        host_tx_o
);
    logic              line_s;
    logic              fall_s;
    logic              busy;
    logic [HALF_W-1:0] half;

    echo_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (host_rx_i),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    echo_frame_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (fall_s),
        .busy_o  (busy),
        .half_o  (half)
    );

    echo_phase_mux u_mux (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_s),
        .busy_i (busy),
        .half_i (half),
        .pins_i (pins_i),
        .out_o  (host_tx_o)
    );

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !line_s);

    p_start_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && half < HALF_W'(GAP_HALF)) |=> (host_tx_o == $past(line_s)));

endmodule

// File: tb/echo_input_mux_bench.sv
module echo_input_mux_bench;
    localparam int CPB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_rx = 1'b1;
    logic [3:0] pins = 4'h0;
    logic       host_tx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    echo_input_mux #(.CLKS_PER_BIT(CPB), .SYNC_STAGES(2)) u_echo_input_mux (
        .clk       (clk),
        .rst       (rst),
        .host_rx_i (host_rx),
        .pins_i    (pins),
        .host_tx_o (host_tx)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic frame_bit(input logic [7:0] ch, input int t);
        int b;
        b = t / CPB;
        if (b == 0) return 1'b0;
        if (b <= 8) return ch[b-1];
        return 1'b1;
    endfunction

    // One character; t counts bench negedges from the start edge.
    // flip_t >= 0 toggles pin 0 at that time (live-sampling test).
    task automatic run_frame(input logic [7:0] ch, input logic [3:0] pv,
                             input bit burst, input int flip_t);
        logic [3:0] cur;
        cur = pv;
        for (int t = 0; t < 10 * CPB; t++) begin
            @(negedge clk);
            host_rx = frame_bit(ch, t);
            if (t == flip_t) cur[0] = ~cur[0];
            pins = cur;
            if (t == CPB / 2) chk(burst ? "R7 start" : "R2 start", host_tx, 1'b0);
            if (t == CPB + 6) chk("R3 mark", host_tx, 1'b1);
            if (flip_t >= 0) begin
                if (t == 2 * CPB) chk("R6 before", host_tx, pv[0]);
                if (t == 3 * CPB - 2) chk("R6 after", host_tx, ~pv[0]);
            end else begin
                if (t == 2 * CPB + CPB / 2) chk("R4 pin0", host_tx, pv[0]);
            end
            if (t == 3 * CPB + CPB / 2) chk("R4 pin1", host_tx, pv[1]);
            if (t == 5 * CPB + CPB / 2) chk("R4 pin2", host_tx, pv[2]);
            if (t == 6 * CPB + CPB / 2) chk("R4 pin3", host_tx, pv[3]);
            if (t == 8 * CPB + CPB / 2) chk(burst ? "R7 msb" : "R5 msb", host_tx, ch[7]);
            if (t == 9 * CPB + CPB / 2) chk("R5 stop", host_tx, 1'b1);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_rx = 1'b1;
            if (i == n - 1) chk("R1 idle", host_tx, 1'b1);
        end
    endtask

    initial begin
        logic [7:0] chars [5];
        chars = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h55};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset", host_tx, 1'b1);
        idle(10);
        for (int c = 0; c < 5; c++) begin
            for (int p = 0; p < 16; p++) begin
                run_frame(chars[c], 4'(p), 1'b0, -1);
                idle(8);
            end
        end
        // back-to-back burst, no idle between characters
        for (int p = 0; p < 16; p++) begin
            run_frame(8'(p * 17 + 3) ^ {p[0], 7'h0}, 4'(15 - p), 1'b1, -1);
        end
        idle(8);
        run_frame(8'hA5, 4'b0110, 1'b0, 2 * CPB + 4);
        idle(8);
        run_frame(8'h3C, 4'b1001, 1'b0, 2 * CPB + 4);
        idle(20);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule